// File: doc/BRIEF.md
# Pulse-Count Trim Programming Register

This block sets an oscillator trim code from a count of short low pulses on a single open-drain style data line. Counting only happens when programming is enabled and the select line is low. After each counted pulse the new count is copied into a working latch. The latch drives the time base straight away, so a trim value can be tried out before anyone commits it. If the data line is held low for a long time, a one-cycle write strobe is raised, and the working value is handed to an external nonvolatile store.

A separate verify mode is active when programming is disabled and the select line is high. In this mode the block drives a seven-segment-wide output with the complement of the code read back from the store. A stored 1 therefore lights its segment, and segments are active low. Every asynchronous input passes through a synchronizer. The long-press threshold is a cycle-count parameter; its default equals 10 ms at 200 MHz.

Top module: `trim_prog_reg`

## Requirements
- R1: After reset, `trim_code` is 0, `store_we` is 0, and `seg_drv` is all ones (every segment off).
- R2: Load mode is `prog_en`=1 and `select`=0. In load mode, each low pulse on `data_n` that ends before the long-press threshold adds one to the input count. `trim_code` takes the new count once the pulse has been released.
- R3: The input count saturates at 2^CODE_W-1 (127 by default) and never wraps to 0.
- R4: Holding `data_n` low for STORE_CYC synchronized cycles in load mode raises `store_we` for exactly one cycle, with `store_wdata` equal to `trim_code`. That press does not change the count.
- R5: Any change of `select`, rising or falling, clears the input count and leaves `trim_code` unchanged. The next counted pulse then gives `trim_code` = 1.
- R6: A falling edge of `prog_en` clears the input count and leaves `trim_code` unchanged. The next counted pulse then gives `trim_code` = 1.
- R7: Outside load mode, neither short nor long lows on `data_n` change `trim_code` or raise `store_we`.
- R8: Verify mode is `prog_en`=0 and `select`=1. In verify mode, `seg_drv` equals the bitwise complement of `nv_code`, and bit i stands for pulse weight 2^i (bit 6 = weight 64, bit 0 = weight 1). In every other mode `seg_drv` is all ones.
- R9: `store_we` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_n | input | 1 | Pulse line, active low, asynchronous |
| select | input | 1 | Mode select, asynchronous |
| prog_en | input | 1 | Programming enable, asynchronous |
| nv_code | input | CODE_W | Code read back from the nonvolatile store |
| trim_code | output | CODE_W | Working trim latch driving the time base |
| store_we | output | 1 | One-cycle commit strobe to the store |
| store_wdata | output | CODE_W | Value to commit |
| seg_drv | output | CODE_W | Verify segment drive, active low |

## Verification
A wrong input count shows on `trim_code` a few cycles after the next released pulse, which is about four clock edges after the release reaches the pins. A missed clear shows the same way, because the value seen after a clear is 1 and not old count + 1. A wrong long-press timer shows as a missing strobe, or as a strobe that repeats, or as a long press that also bumps the count. Each of these is visible at `store_we` and `trim_code` within a few cycles of the threshold. A wrong verify map shows on `seg_drv` within three cycles of entering the mode.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_LOAD   = 2'd1,
      MODE_VERIFY = 2'd2
   } trim_mode_e;

   function automatic trim_mode_e decode_mode(input logic pe, input logic sel);
      if (pe && !sel)      return MODE_LOAD;
      else if (!pe && sel) return MODE_VERIFY;
      else                 return MODE_IDLE;
   endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int          STAGES  = 2,
   parameter int          WIDTH   = 1,
   parameter logic [31:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2) $error("trim_sync: STAGES must be at least 2");
      if (WIDTH < 1 || WIDTH > 32) $error("trim_sync: WIDTH out of range");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL[WIDTH-1:0];
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s > 0) ? s-1 : 0];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/trim_press_timer.sv
module trim_press_timer #(
   parameter int STORE_CYC = 2_000_000,
   localparam int CNT_W = $clog2(STORE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic short_done,
   output logic long_hit
);
   initial begin
      if (STORE_CYC < 2) $error("trim_press_timer: STORE_CYC must be at least 2");
   end

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STORE_CYC);

   logic             line_q;
   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b1;
         low_cnt <= '0;
      end else begin
         line_q <= line_n;
         if (line_n)             low_cnt <= '0;
         else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
      end
   end

   assign short_done = line_n && !line_q && (low_cnt != LIMIT);
   assign long_hit   = !line_n && (low_cnt == LIMIT - 1'b1);

   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      long_hit |=> !long_hit);
   assert_long_not_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      long_hit |=> !short_done);
endmodule

// File: rtl/trim_verify_drive.sv
module trim_verify_drive #(
   parameter int CODE_W     = 7,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] seg
);
   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg = en ? ~code : '1;
      end else begin : g_high
         assign seg = en ? code : '0;
      end
   endgenerate
endmodule

// File: rtl/trim_prog_reg.sv
module trim_prog_reg
   import trim_prog_pkg::*;
#(
   parameter int CODE_W      = 7,
   parameter int STORE_CYC   = 2_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_n,
   input  logic              select,
   input  logic              prog_en,
   input  logic [CODE_W-1:0] nv_code,
   output logic [CODE_W-1:0] trim_code,
   output logic              store_we,
   output logic [CODE_W-1:0] store_wdata,
   output logic [CODE_W-1:0] seg_drv
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   initial begin
      if (CODE_W < 1 || CODE_W > 16) $error("trim_prog_reg: CODE_W out of range");
   end

   logic [2:0] raw_in, sync_in;
   logic       data_s, sel_s, pe_s, sel_q, pe_q;
   logic       short_done, long_hit;
   trim_mode_e mode;
   logic       clr_in;
   logic [CODE_W-1:0] in_cnt, work_q, wdata_q, cnt_next;
   logic       we_q;

   assign raw_in = {prog_en, select, data_n};

   trim_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(32'd1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in));

   assign data_s = sync_in[0];
   assign sel_s  = sync_in[1];
   assign pe_s   = sync_in[2];

   trim_press_timer #(.STORE_CYC(STORE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .line_n(data_s),
      .short_done(short_done), .long_hit(long_hit));

   assign mode     = decode_mode(pe_s, sel_s);
   assign clr_in   = (sel_s != sel_q) || (pe_q && !pe_s);
   assign cnt_next = (in_cnt == CODE_MAX) ? CODE_MAX : in_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         pe_q    <= 1'b0;
         in_cnt  <= '0;
         work_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else begin
         sel_q <= sel_s;
         pe_q  <= pe_s;
         we_q  <= long_hit && (mode == MODE_LOAD);
         if (long_hit && (mode == MODE_LOAD)) wdata_q <= work_q;
         if (clr_in) begin
            in_cnt <= '0;
         end else if (short_done && (mode == MODE_LOAD)) begin
            in_cnt <= cnt_next;
            work_q <= cnt_next;
         end
      end
   end

   trim_verify_drive #(.CODE_W(CODE_W), .ACTIVE_LOW(1'b1)) u_verify (
      .en(mode == MODE_VERIFY), .code(nv_code), .seg(seg_drv));

   assign trim_code   = work_q;
   assign store_we    = we_q;
   assign store_wdata = wdata_q;

   assert_step_or_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (work_q != $past(work_q)) |-> (work_q == $past(work_q) + 1'b1 || work_q == CODE_W'(1)));
   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (work_q != '0) |=> (work_q != '0));
   assert_commit_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |-> (store_wdata == trim_code));
   assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_LOAD) |=> ($stable(work_q) && !we_q));
   assert_single_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |=> !store_we);
endmodule

// File: tb/tb_trim_prog_reg.sv
module tb_trim_prog_reg;
   localparam int CODE_W = 7;
   localparam int STORE_CYC = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic data_n = 1'b1, select = 1'b0, prog_en = 1'b1;
   logic [CODE_W-1:0] nv_code = '0;
   logic [CODE_W-1:0] trim_code, store_wdata, seg_drv;
   logic store_we;

   always #2.5 clk = ~clk;

   trim_prog_reg #(.CODE_W(CODE_W), .STORE_CYC(STORE_CYC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .data_n(data_n), .select(select), .prog_en(prog_en),
      .nv_code(nv_code), .trim_code(trim_code), .store_we(store_we),
      .store_wdata(store_wdata), .seg_drv(seg_drv));

   typedef struct { int kind; string req; int exp; } item_t;
   item_t q[$];
   int checks = 0, errors = 0, stores = 0, last_wdata = 0;
   bit done = 1'b0;

   // monitor: counts strobes and pops expected items
   always @(negedge clk) begin
      if (rst_n && store_we) begin
         stores++;
         last_wdata = int'(store_wdata);
      end
      if (q.size() > 0) begin
         item_t it;
         int act;
         it = q.pop_front();
         case (it.kind)
            0: act = int'(trim_code);
            1: act = int'(seg_drv);
            2: act = stores;
            default: act = last_wdata;
         endcase
         checks++;
         if (act != it.exp) begin
            errors++;
            $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic expect_item(int kind, string req, int exp);
      item_t it;
      it.kind = kind; it.req = req; it.exp = exp;
      q.push_back(it);
      repeat (2) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(int low_cyc);
      @(negedge clk); data_n = 1'b0;
      idle(low_cyc);
      data_n = 1'b1;
      idle(8);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(6);
      expect_item(0, "R1", 0);
      expect_item(1, "R1", 127);
      expect_item(2, "R1", 0);

      pulse(4);
      expect_item(0, "R2", 1);
      pulse(3); pulse(5);
      expect_item(0, "R2", 3);

      pulse(STORE_CYC + 20);
      expect_item(2, "R4", 1);
      expect_item(3, "R4", 3);
      expect_item(0, "R4", 3);

      select = 1'b1; idle(6); select = 1'b0; idle(6);
      expect_item(0, "R5", 3);
      pulse(4);
      expect_item(0, "R5", 1);

      select = 1'b1; idle(6);
      pulse(4); pulse(4);
      expect_item(0, "R7", 1);
      pulse(STORE_CYC + 20);
      expect_item(2, "R7", 1);
      expect_item(0, "R7", 1);
      select = 1'b0; idle(6);

      pulse(4); pulse(4); pulse(4);
      expect_item(0, "R2", 3);
      prog_en = 1'b0; idle(6); prog_en = 1'b1; idle(6);
      expect_item(0, "R6", 3);
      pulse(4);
      expect_item(0, "R6", 1);

      for (int i = 0; i < 130; i++) pulse(3);
      expect_item(0, "R3", 127);
      pulse(3);
      expect_item(0, "R3", 127);

      pulse(STORE_CYC + 20);
      expect_item(2, "R4", 2);
      expect_item(3, "R4", 127);

      prog_en = 1'b0; select = 1'b1; nv_code = 7'h53; idle(6);
      expect_item(1, "R8", 8'h2C);
      nv_code = 7'h40; idle(2);
      expect_item(1, "R8", 8'h3F);
      select = 1'b0; idle(6);
      expect_item(1, "R8", 127);
      expect_item(0, "R8", 127);

      idle(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule